// File: doc/BRIEF.md
# Bitmap Shape Checker

The block keeps a 16×16 one-bit image that is built up one pixel at a time from write transactions. Each write names a pixel through the low byte of its address and stores one data bit there. A pixel holds the bit of the most recent write to it, and reset clears the whole image to zero.

A sync transaction names a shape and a radius. On sync the block compares the stored image, one row of 16 pixels per cycle, against the image that shape and radius call for. It then reports the result on `match` with a one-cycle `done` pulse. The block drops writes and syncs that arrive while a comparison is running, and shows this on `busy`.

Pixel coordinates are signed and centred: the pixel at row index i and column index j stands for x = i − 8 and y = j − 8.

Top module: `shapeChk`

## Requirements
- R1: After reset every pixel is zero, and `busy`, `done` and `match` are low. A blank sync issued at that point reports a match.
- R2: A write stores `wrData` at row index `wrAddr[7:4]` and column index `wrAddr[3:0]`. A pixel holds the value of its latest write.
- R3: Address bits 15:8 have no effect on which pixel is written.
- R4: Shape code 1 (circle) of radius r matches only when every pixel equals (x² + y² ≤ r²).
- R5: Shape code 0 (square) of radius r matches only when the set pixels are exactly those with |x| ≤ r and |y| ≤ r.
- R6: Shape code 2 (triangle) of radius r matches only when the set pixels are exactly those with x ≥ 0, y ≥ 0 and x + y ≤ r.
- R7: Shape code 3 (blank) matches only when every pixel is zero.
- R8: The block accepts a sync in any cycle where `busy` is low. `busy` is then high for the 16 cycles that follow. In the cycle after those 16, `done` is high for exactly one cycle with `busy` low. `match` changes only together with `done` and holds its value until the next `done`.
- R9: Writes and syncs presented while `busy` is high are dropped. The image and the running comparison are unchanged.
- R10: When a write and a sync arrive in the same idle cycle, the write is stored before the comparison starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrValid | input | 1 | Write transaction present |
| wrAddr | input | 16 | Write address; bits 7:4 give the row index, bits 3:0 the column index |
| wrData | input | 1 | Pixel value to store |
| syncValid | input | 1 | Sync transaction present |
| syncShape | input | 2 | Shape code: 0 square, 1 circle, 2 triangle, 3 blank |
| syncRadius | input | 3 | Shape radius |
| busy | output | 1 | Comparison running; inputs are dropped |
| done | output | 1 | One-cycle pulse when a result is ready |
| match | output | 1 | Result of the last comparison |

## Verification
A single wrong stored pixel shows up at the ports only after the next sync, 17 cycles later, as a wrong `match`. For that reason the bench paints every shape at every radius and checks it against all four shape codes. It also flips single pixels and checks that the change is caught. A wrong row counter or a wrong control state shows within the same sync as a `busy` window of the wrong length or a misplaced `done`. A write that slips through during a scan shows on the next sync.

// File: rtl/shapeChkPkg.sv
package shapeChkPkg;

  typedef enum logic [1:0] {
    SHP_SQUARE   = 2'd0,
    SHP_CIRCLE   = 2'd1,
    SHP_TRIANGLE = 2'd2,
    SHP_BLANK    = 2'd3
  } shape_e;

  // strobes from control to datapath
  typedef struct packed {
    logic wrEn;
    logic latchCmd;
    logic scanEn;
    logic scanFirst;
    logic scanLast;
  } strobe_t;

endpackage

// File: rtl/shapeChkCtrl.sv
module shapeChkCtrl
  import shapeChkPkg::*;
#(
  parameter int CoordW = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  input  logic              syncValid,
  output strobe_t           strb,
  output logic [CoordW-1:0] rowIdx,
  output logic              busy
);

  localparam logic [CoordW-1:0] LastRow = '1;

  typedef enum logic {ST_IDLE, ST_SCAN} state_e;
  state_e state;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      rowIdx <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          rowIdx <= '0;
          if (syncValid) state <= ST_SCAN;
        end
        ST_SCAN: begin
          rowIdx <= rowIdx + 1'b1;
          if (rowIdx == LastRow) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    busy           = (state == ST_SCAN);
    strb.wrEn      = wrValid && !busy;
    strb.latchCmd  = syncValid && !busy;
    strb.scanEn    = busy;
    strb.scanFirst = busy && (rowIdx == '0);
    strb.scanLast  = busy && (rowIdx == LastRow);
  end

  AST_SCAN_LEN: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(rowIdx) == LastRow); // R8

  AST_SCAN_START: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> rowIdx == '0); // R8

endmodule

// File: rtl/shapeChkData.sv
module shapeChkData
  import shapeChkPkg::*;
#(
  parameter int CoordW = 4,
  parameter int RadW   = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [CoordW-1:0] rowIdx,
  input  logic [CoordW-1:0] wrRow,
  input  logic [CoordW-1:0] wrCol,
  input  logic              wrData,
  input  shape_e            cmdShape,
  input  logic [RadW-1:0]   cmdRadius,
  output logic              done,
  output logic              match
);

  localparam int Grid   = 1 << CoordW;
  localparam int Center = Grid / 2;

  logic [Grid-1:0][Grid-1:0] pix;
  shape_e                    shapeReg;
  logic [RadW-1:0]           radReg;
  logic [Grid-1:0]           expRow;
  logic                      rowOk;
  logic                      accOk;

  function automatic logic pixelWanted(shape_e s, int r, int x, int y);
    logic res;
    case (s)
      SHP_CIRCLE:   res = (x * x + y * y) <= (r * r);
      SHP_SQUARE:   res = (x >= -r) && (x <= r) && (y >= -r) && (y <= r);
      SHP_TRIANGLE: res = (x >= 0) && (y >= 0) && (x + y <= r);
      default:      res = 1'b0;
    endcase
    return res;
  endfunction

  // image store
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pix <= '0;
    end else if (strb.wrEn) begin
      pix[wrRow][wrCol] <= wrData;
    end
  end

  // command capture
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shapeReg <= SHP_SQUARE;
      radReg   <= '0;
    end else if (strb.latchCmd) begin
      shapeReg <= cmdShape;
      radReg   <= cmdRadius;
    end
  end

  // expected pattern for the row under scan
  for (genvar col = 0; col < Grid; col++) begin : g_col
    always_comb begin
      expRow[col] = pixelWanted(shapeReg, int'(radReg),
                                int'(rowIdx) - Center, col - Center);
    end
  end

  assign rowOk = (pix[rowIdx] == expRow);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accOk <= 1'b0;
      done  <= 1'b0;
      match <= 1'b0;
    end else begin
      done <= strb.scanLast;
      if (strb.scanEn) accOk <= (strb.scanFirst ? 1'b1 : accOk) && rowOk;
      if (strb.scanLast) match <= accOk && rowOk;
    end
  end

  AST_IMAGE_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    strb.scanEn |=> $stable(pix)); // R9

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R8

  AST_MATCH_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable(match)); // R8

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    strb.scanEn |=> $stable(radReg) && $stable(shapeReg)); // R9

endmodule

// File: rtl/shapeChk.sv
module shapeChk
  import shapeChkPkg::*;
#(
  parameter int AddrW  = 16,
  parameter int CoordW = 4,
  parameter int RadW   = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrValid,
  input  logic [AddrW-1:0] wrAddr,
  input  logic             wrData,
  input  logic             syncValid,
  input  logic [1:0]       syncShape,
  input  logic [RadW-1:0]  syncRadius,
  output logic             busy,
  output logic             done,
  output logic             match
);

  strobe_t           strb;
  logic [CoordW-1:0] rowIdx;

  shapeChkCtrl #(.CoordW(CoordW)) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .wrValid   (wrValid),
    .syncValid (syncValid),
    .strb      (strb),
    .rowIdx    (rowIdx),
    .busy      (busy)
  );

  shapeChkData #(.CoordW(CoordW), .RadW(RadW)) i_data (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .rowIdx    (rowIdx),
    .wrRow     (wrAddr[2*CoordW-1:CoordW]),
    .wrCol     (wrAddr[CoordW-1:0]),
    .wrData    (wrData),
    .cmdShape  (shape_e'(syncShape)),
    .cmdRadius (syncRadius),
    .done      (done),
    .match     (match)
  );

endmodule

// File: tb/test_shapeChk.sv
`timescale 1ns/1ps
module test_shapeChk;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrValid = 1'b0;
  logic [15:0] wrAddr = '0;
  logic        wrData = 1'b0;
  logic        syncValid = 1'b0;
  logic [1:0]  syncShape = '0;
  logic [2:0]  syncRadius = '0;
  logic        busy, done, match;

  int  nTests = 0;
  int  nFails = 0;
  bit  model [16][16];

  always #2.5 clk = ~clk;

  shapeChk i_shapeChk (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrAddr(wrAddr), .wrData(wrData),
    .syncValid(syncValid), .syncShape(syncShape), .syncRadius(syncRadius),
    .busy(busy), .done(done), .match(match)
  );

  task automatic check(bit ok, string req, int act, int exp);
    nTests++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // shape rules with x,y centred on index 8
  function automatic bit inShape(int s, int r, int x, int y);
    int ax = (x < 0) ? -x : x;
    int ay = (y < 0) ? -y : y;
    if (s == 1) return (ax * ax + ay * ay) <= r * r;
    if (s == 0) return (ax <= r) && (ay <= r);
    if (s == 2) return (x >= 0) && (y >= 0) && (x + y <= r);
    return 1'b0;
  endfunction

  function automatic bit modelMatch(int s, int r);
    for (int i = 0; i < 16; i++)
      for (int j = 0; j < 16; j++)
        if (model[i][j] != inShape(s, r, i - 8, j - 8)) return 1'b0;
    return 1'b1;
  endfunction

  function automatic string shapeTag(int s);
    if (s == 0) return "R5";
    if (s == 1) return "R4";
    if (s == 2) return "R6";
    return "R7";
  endfunction

  task automatic writePix(int i, int j, bit d, int hi);
    @(negedge clk);
    wrValid = 1'b1;
    wrAddr  = {8'(hi), 4'(i), 4'(j)};
    wrData  = d;
    model[i][j] = d;
    @(negedge clk);
    wrValid = 1'b0;
  endtask

  // paints the whole image; upper address bits vary (R3)
  task automatic paint(int s, int r);
    for (int i = 0; i < 16; i++)
      for (int j = 0; j < 16; j++) begin
        @(negedge clk);
        wrValid = 1'b1;
        wrAddr  = {8'((s * 37 + r * 11 + i) | 1), 4'(i), 4'(j)};
        wrData  = inShape(s, r, i - 8, j - 8);
        model[i][j] = wrData;
      end
    @(negedge clk);
    wrValid = 1'b0;
  endtask

  // mode 0: plain, 1: write pixel (pi,pj)=1 in the sync cycle, 2: inject flip and sync mid-scan
  task automatic runSync(int s, int r, string tag, int mode, int pi, int pj);
    bit exp;
    bit winBad = 1'b0;
    @(negedge clk);
    syncValid  = 1'b1;
    syncShape  = 2'(s);
    syncRadius = 3'(r);
    if (mode == 1) begin
      wrValid = 1'b1; wrAddr = {8'h00, 4'(pi), 4'(pj)}; wrData = 1'b1;
      model[pi][pj] = 1'b1;
    end
    exp = modelMatch(s, r);
    @(negedge clk);
    syncValid = 1'b0;
    wrValid   = 1'b0;
    if (!busy || done) winBad = 1'b1;
    for (int k = 1; k < 16; k++) begin
      if (mode == 2 && k == 5) begin
        wrValid = 1'b1; wrAddr = {8'h00, 4'(pi), 4'(pj)}; wrData = !model[pi][pj];
        syncValid = 1'b1; syncShape = 2'(3 - s); syncRadius = 3'(7 - r);
      end
      @(negedge clk);
      wrValid = 1'b0;
      syncValid = 1'b0;
      if (!busy || done) winBad = 1'b1;
    end
    @(negedge clk);
    check(!winBad && done && !busy, "R8", {winBad, done, busy}, 3'b010);
    check(match == exp, tag, match, exp);
    @(negedge clk);
    check(!done && match == exp, "R8", {done, match}, {1'b0, exp});
  endtask

  initial begin
    for (int i = 0; i < 16; i++)
      for (int j = 0; j < 16; j++) model[i][j] = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !done && !match, "R1", {busy, done, match}, 0);
    runSync(3, 0, "R1", 0, 0, 0);
    runSync(1, 0, "R4", 0, 0, 0);

    // R10: simultaneous write of the origin and a circle r0 sync
    runSync(1, 0, "R10", 1, 8, 8);
    runSync(3, 0, "R7", 0, 0, 0);

    // full sweep: every shape at every radius against every shape code
    for (int s = 0; s < 4; s++)
      for (int r = 0; r < 8; r++) begin
        paint(s, r);
        for (int q = 0; q < 4; q++) runSync(q, r, shapeTag(q), 0, 0, 0);
        runSync(1, (r + 3) % 8, "R4", 0, 0, 0);
        runSync(0, (r + 5) % 8, "R5", 0, 0, 0);
      end

    // R2: single-pixel flip is caught; latest write wins
    paint(1, 5);
    writePix(10, 9, 1'b0, 0);
    runSync(1, 5, "R2", 0, 0, 0);
    check(modelMatch(1, 5) == 1'b0, "R2", modelMatch(1, 5), 0);
    writePix(10, 9, 1'b0, 0);
    writePix(10, 9, 1'b1, 0);
    runSync(1, 5, "R2", 0, 0, 0);
    writePix(0, 0, 1'b1, 0);
    runSync(1, 5, "R4", 0, 0, 0);
    writePix(0, 0, 1'b0, 0);

    // R9: write and sync injected mid-scan are dropped
    runSync(1, 5, "R9", 2, 8, 8);
    runSync(1, 5, "R9", 0, 0, 0);

    // R3: upper address bits all ones still hit pixel (8,8)
    paint(3, 0);
    writePix(8, 8, 1'b1, 8'hFF);
    runSync(1, 0, "R3", 0, 0, 0);
    runSync(3, 0, "R3", 0, 0, 0);

    $display("[TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    nTests++;
    nFails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end

endmodule